// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Unit with Access Rings

This block maps a 32-bit virtual address to a physical address through a small set-associative translation buffer. The buffer has several ways, and each way holds a few entries. Every entry stores a virtual page number, a physical page number, an 8-bit address-space tag and a 4-bit attribute code. A lookup reads one entry from each way at the index given by the low bits of the page number. From the entry that hits, the block derives the access ring by searching a four-byte tag register, and it checks that ring against the privilege level of the request. It then decodes read, write and execute rights from the attribute code and checks them against the kind of access. It returns the physical address, the rights, the ring, the way that hit, and an encoded fault cause.

On the same request the block also produces the address of the page-table entry that a hardware refill would fetch. A separate refill input accepts a fetched page-table entry. It writes that entry into a way chosen by a rotating counter. The memory read itself happens outside the block. Software can also write any entry directly, and it can load the tag register.

Top module: `tlb_ring_xlate`

## Requirements
- R1: An entry hits only when its stored virtual page number equals vaddr[31:12] and its tag is nonzero. The entry is read at index vaddr[13:12]. A lookup with no hit reports cause 1 for a fetch (req_kind 2 or 3) and cause 5 for a load (0) or a store (1).
- R2: The ring is the lowest index i (0..3) for which byte i of the tag register, bits [8i+7:8i], equals the tag of the entry that hit. The tag register resets to 0x04030201, and a write through asid_we replaces it.
- R3: A hit in more than one way reports cause 2 for a fetch and cause 6 for a data access. In that case paddr_o and rights_o are zero.
- R4: A hit whose ring is below req_priv reports cause 3 for a fetch and cause 7 for a data access.
- R5: For attribute codes below 12, bit 0 grants execute, bit 1 grants write, and read is always granted. Code 13 grants read and write. All other codes grant nothing. rights_o is {X,W,R}. Data lookups drop X, and fetches drop R and W. A missing right reports cause 4 for a fetch, cause 8 for a load and cause 9 for a store.
- R6: On a hit without a fault, paddr_o is the entry's physical page number followed by vaddr[11:0]. way_o gives the way that hit.
- R7: pte_addr_o is (pt_base OR (vaddr >> 10)) with bits [1:0] cleared.
- R8: Each refill first increments a counter that resets to 0, then writes the way equal to the counter's two low bits. So the first refill after reset writes way 1. The written entry takes its page number from fill_vaddr[31:12], its physical page from fill_pte[31:12], its tag from the tag-register byte selected by fill_pte[5:4], and its attribute from fill_pte[3:0].
- R9: Reset clears every entry's tag, so every lookup after reset misses.
- R10: Results appear in the cycle after req_valid, with done_o high for exactly that cycle. Miss and multi-hit take precedence over the privilege fault, which in turn takes precedence over the rights fault. fault_o is high exactly when cause_o is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| asid_we | input | 1 | Load the tag register |
| asid_wdata | input | 32 | New tag register value, four byte-wide tags |
| ent_we | input | 1 | Direct entry write |
| ent_way | input | 2 | Way for the direct write |
| ent_idx | input | 2 | Index for the direct write |
| ent_vpn | input | 20 | Virtual page number to store |
| ent_ppn | input | 20 | Physical page number to store |
| ent_asid | input | 8 | Tag to store |
| ent_attr | input | 4 | Attribute code to store |
| pt_base | input | 32 | Base virtual address of the page table |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | 0 load, 1 store, 2 or 3 fetch |
| req_priv | input | 2 | Requested privilege index |
| fill_valid | input | 1 | Refill with a fetched page-table entry |
| fill_vaddr | input | 32 | Virtual address the refill covers |
| fill_pte | input | 32 | Fetched page-table entry |
| done_o | output | 1 | Lookup result valid |
| fault_o | output | 1 | Lookup faulted |
| cause_o | output | 4 | Fault cause code, 0 when no fault |
| paddr_o | output | 32 | Physical address |
| rights_o | output | 3 | Granted rights {X,W,R} |
| ring_o | output | 2 | Ring of the entry that hit |
| way_o | output | 2 | Way that hit |
| pte_addr_o | output | 32 | Page-table entry address for a refill |

## Verification
The multi-hit fault is the hardest case to reach. A correct refill path never places two matching copies in one set, so the bench uses the direct write port to put the same page number with a nonzero tag into two ways at one index. It then clears one copy and confirms that the single hit comes back. A second difficult case is the wrap of the refill way sequence. The bench issues four refills to distinct pages that share one index. It then looks up each page and checks that they landed in ways 1, 2, 3 and then 0, and that the fourth refill replaced the entry already held in way 0.

// File: rtl/tlbr_pkg.sv
package tlbr_pkg;
    localparam int VA_W    = 32;
    localparam int PG_SHIFT = 12;
    localparam int VPN_W   = VA_W - PG_SHIFT;
    localparam int ASID_W  = 8;
    localparam int ATTR_W  = 4;
    localparam int NRING   = 4;
    localparam int PTE_SHIFT = 10;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [VPN_W-1:0]  ppn;
        logic [ASID_W-1:0] asid;
        logic [ATTR_W-1:0] attr;
    } tlb_ent_t;

    typedef enum logic [3:0] {
        CA_NONE    = 4'd0,
        CA_I_MISS  = 4'd1,
        CA_I_MULTI = 4'd2,
        CA_I_PRIV  = 4'd3,
        CA_I_PROT  = 4'd4,
        CA_D_MISS  = 4'd5,
        CA_D_MULTI = 4'd6,
        CA_D_PRIV  = 4'd7,
        CA_LD_PROT = 4'd8,
        CA_ST_PROT = 4'd9
    } cause_e;
endpackage

// File: rtl/tlbr_ring_find.sv
module tlbr_ring_find
    import tlbr_pkg::*;
(
    input  logic [NRING*ASID_W-1:0] tags_i,
    input  logic [ASID_W-1:0]       asid_i,
    output logic [1:0]              ring_o,
    output logic                    found_o
);
    logic [NRING-1:0] match;

    for (genvar i = 0; i < NRING; i++) begin : g_cmp
        assign match[i] = (tags_i[i*ASID_W +: ASID_W] == asid_i);
    end

    always_comb begin
        ring_o  = 2'd3;
        found_o = 1'b0;
        for (int i = NRING - 1; i >= 0; i--) begin
            if (match[i]) begin
                ring_o  = 2'(i);
                found_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tlbr_rights.sv
module tlbr_rights
    import tlbr_pkg::*;
(
    input  logic [ATTR_W-1:0] attr_i,
    input  logic              fetch_i,
    output logic [2:0]        rights_o
);
    logic [2:0] raw;

    always_comb begin
        if (attr_i < ATTR_W'(12)) begin
            raw = {attr_i[0], attr_i[1], 1'b1};
        end else if (attr_i == ATTR_W'(13)) begin
            raw = 3'b011;
        end else begin
            raw = 3'b000;
        end
        rights_o = fetch_i ? (raw & 3'b100) : (raw & 3'b011);
    end
endmodule

// File: rtl/tlbr_array.sv
module tlbr_array
    import tlbr_pkg::*;
#(
    parameter int NWAYS = 4,
    parameter int IDX_W = 2,
    localparam int WAY_W = (NWAYS > 1) ? $clog2(NWAYS) : 1,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we_i,
    input  logic [WAY_W-1:0]           way_i,
    input  logic [IDX_W-1:0]           widx_i,
    input  tlb_ent_t                   went_i,
    input  logic [IDX_W-1:0]           ridx_i,
    output tlb_ent_t [NWAYS-1:0]       rent_o
);
    tlb_ent_t mem_q [NWAYS][DEPTH];
    tlb_ent_t mem_d [NWAYS][DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we_i) begin
            mem_d[way_i][widx_i] = went_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NWAYS; w++) begin
                for (int e = 0; e < DEPTH; e++) begin
                    mem_q[w][e] <= '0;
                end
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar w = 0; w < NWAYS; w++) begin : g_rd
        assign rent_o[w] = mem_q[w][ridx_i];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> mem_q[$past(way_i)][$past(widx_i)] == $past(went_i)); // R8
endmodule

// File: rtl/tlb_ring_xlate.sv
module tlb_ring_xlate
    import tlbr_pkg::*;
#(
    parameter int NWAYS = 4,
    parameter int IDX_W = 2,
    parameter int CNT_W = 8,
    parameter logic [31:0] ASID_RST = 32'h0403_0201,
    localparam int WAY_W = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 asid_we,
    input  logic [31:0]          asid_wdata,
    input  logic                 ent_we,
    input  logic [WAY_W-1:0]     ent_way,
    input  logic [IDX_W-1:0]     ent_idx,
    input  logic [VPN_W-1:0]     ent_vpn,
    input  logic [VPN_W-1:0]     ent_ppn,
    input  logic [ASID_W-1:0]    ent_asid,
    input  logic [ATTR_W-1:0]    ent_attr,
    input  logic [VA_W-1:0]      pt_base,
    input  logic                 req_valid,
    input  logic [VA_W-1:0]      req_vaddr,
    input  logic [1:0]           req_kind,
    input  logic [1:0]           req_priv,
    input  logic                 fill_valid,
    input  logic [VA_W-1:0]      fill_vaddr,
    input  logic [VA_W-1:0]      fill_pte,
    output logic                 done_o,
    output logic                 fault_o,
    output logic [3:0]           cause_o,
    output logic [VA_W-1:0]      paddr_o,
    output logic [2:0]           rights_o,
    output logic [1:0]           ring_o,
    output logic [WAY_W-1:0]     way_o,
    output logic [VA_W-1:0]      pte_addr_o
);
    typedef struct packed {
        logic              done;
        logic              fetch;
        cause_e            cause;
        logic [VA_W-1:0]   paddr;
        logic [2:0]        rights;
        logic [1:0]        ring;
        logic [WAY_W-1:0]  way;
        logic [VA_W-1:0]   pte_addr;
        logic [CNT_W-1:0]  cnt;
        logic [31:0]       tags;
    } state_t;

    state_t st_d, st_q;

    // lookup side
    logic [VPN_W-1:0]      req_vpn;
    logic [IDX_W-1:0]      req_idx;
    logic                  req_fetch;
    tlb_ent_t [NWAYS-1:0]  rd_ent;
    logic [NWAYS-1:0]      hit_vec;
    logic [WAY_W-1:0]      hit_way;
    tlb_ent_t              hit_ent;
    logic [1:0]            hit_ring;
    logic                  hit_found;
    logic [2:0]            hit_rights;

    // write side
    logic                  arr_we;
    logic [WAY_W-1:0]      arr_way;
    logic [IDX_W-1:0]      arr_idx;
    tlb_ent_t              arr_ent;
    logic [CNT_W-1:0]      cnt_next;

    assign req_vpn   = req_vaddr[VA_W-1:PG_SHIFT];
    assign req_idx   = req_vpn[IDX_W-1:0];
    assign req_fetch = req_kind[1];

    tlbr_array #(.NWAYS(NWAYS), .IDX_W(IDX_W)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (arr_we),
        .way_i  (arr_way),
        .widx_i (arr_idx),
        .went_i (arr_ent),
        .ridx_i (req_idx),
        .rent_o (rd_ent)
    );

    for (genvar w = 0; w < NWAYS; w++) begin : g_hit
        assign hit_vec[w] = (rd_ent[w].vpn == req_vpn) && (rd_ent[w].asid != '0);
    end

    always_comb begin
        hit_way = '0;
        for (int w = NWAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit_ent = rd_ent[hit_way];

    tlbr_ring_find u_ring (
        .tags_i  (st_q.tags),
        .asid_i  (hit_ent.asid),
        .ring_o  (hit_ring),
        .found_o (hit_found)
    );

    tlbr_rights u_rights (
        .attr_i   (hit_ent.attr),
        .fetch_i  (req_fetch),
        .rights_o (hit_rights)
    );

    // refill and direct write share the array port; refill wins
    assign cnt_next = st_q.cnt + CNT_W'(1);

    always_comb begin
        arr_we  = fill_valid | ent_we;
        arr_way = ent_way;
        arr_idx = ent_idx;
        arr_ent = '{vpn: ent_vpn, ppn: ent_ppn, asid: ent_asid, attr: ent_attr};
        if (fill_valid) begin
            arr_way = WAY_W'(cnt_next[1:0]);
            arr_idx = fill_vaddr[PG_SHIFT +: IDX_W];
            arr_ent.vpn  = fill_vaddr[VA_W-1:PG_SHIFT];
            arr_ent.ppn  = fill_pte[VA_W-1:PG_SHIFT];
            arr_ent.asid = st_q.tags[{fill_pte[5:4], 3'b000} +: ASID_W];
            arr_ent.attr = fill_pte[ATTR_W-1:0];
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (asid_we) st_d.tags = asid_wdata;
        if (fill_valid) st_d.cnt = cnt_next;
        if (req_valid) begin
            st_d.done     = 1'b1;
            st_d.fetch    = req_fetch;
            st_d.way      = hit_way;
            st_d.ring     = 2'd0;
            st_d.paddr    = '0;
            st_d.rights   = '0;
            st_d.cause    = CA_NONE;
            st_d.pte_addr = (pt_base | (req_vaddr >> PTE_SHIFT)) & ~VA_W'(3);
            if (hit_vec == '0) begin
                st_d.cause = req_fetch ? CA_I_MISS : CA_D_MISS;
            end else if ($countones(hit_vec) > 1) begin
                st_d.cause = req_fetch ? CA_I_MULTI : CA_D_MULTI;
            end else begin
                st_d.ring = hit_ring;
                if (hit_found && (hit_ring < req_priv)) begin
                    st_d.cause = req_fetch ? CA_I_PRIV : CA_D_PRIV;
                end else if (req_fetch ? !hit_rights[2] :
                             (req_kind[0] ? !hit_rights[1] : !hit_rights[0])) begin
                    st_d.cause = req_fetch ? CA_I_PROT :
                                 (req_kind[0] ? CA_ST_PROT : CA_LD_PROT);
                end else begin
                    st_d.rights = hit_rights;
                    st_d.paddr  = {hit_ent.ppn, req_vaddr[PG_SHIFT-1:0]};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.cause <= CA_NONE;
            st_q.tags  <= ASID_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o     = st_q.done;
    assign fault_o    = (st_q.cause != CA_NONE);
    assign cause_o    = st_q.cause;
    assign paddr_o    = st_q.paddr;
    assign rights_o   = st_q.rights;
    assign ring_o     = st_q.ring;
    assign way_o      = st_q.way;
    assign pte_addr_o = st_q.pte_addr;

    AST_DONE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done_o); // R10
    AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !done_o); // R10
    AST_FAULT_NO_RIGHTS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o) |-> (rights_o == 3'b000 && paddr_o == '0)); // R3
    AST_FETCH_NO_RW: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && st_q.fetch) |-> (rights_o[1:0] == 2'b00)); // R5
    AST_DATA_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !st_q.fetch) |-> !rights_o[2]); // R5
    AST_FILL_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> (st_q.cnt != $past(st_q.cnt))); // R8
endmodule

// File: tb/tlb_ring_xlate_test.sv
module tlb_ring_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        asid_we;
    logic [31:0] asid_wdata;
    logic        ent_we;
    logic [1:0]  ent_way;
    logic [1:0]  ent_idx;
    logic [19:0] ent_vpn;
    logic [19:0] ent_ppn;
    logic [7:0]  ent_asid;
    logic [3:0]  ent_attr;
    logic [31:0] pt_base;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic [1:0]  req_kind;
    logic [1:0]  req_priv;
    logic        fill_valid;
    logic [31:0] fill_vaddr;
    logic [31:0] fill_pte;
    logic        done_o;
    logic        fault_o;
    logic [3:0]  cause_o;
    logic [31:0] paddr_o;
    logic [2:0]  rights_o;
    logic [1:0]  ring_o;
    logic [1:0]  way_o;
    logic [31:0] pte_addr_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    tlb_ring_xlate uut (
        .clk(clk), .rst_n(rst_n), .asid_we(asid_we), .asid_wdata(asid_wdata),
        .ent_we(ent_we), .ent_way(ent_way), .ent_idx(ent_idx), .ent_vpn(ent_vpn),
        .ent_ppn(ent_ppn), .ent_asid(ent_asid), .ent_attr(ent_attr),
        .pt_base(pt_base), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_priv(req_priv), .fill_valid(fill_valid),
        .fill_vaddr(fill_vaddr), .fill_pte(fill_pte), .done_o(done_o),
        .fault_o(fault_o), .cause_o(cause_o), .paddr_o(paddr_o),
        .rights_o(rights_o), .ring_o(ring_o), .way_o(way_o),
        .pte_addr_o(pte_addr_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_ent(input logic [1:0] w, input logic [31:0] va,
                           input logic [19:0] ppn, input logic [7:0] tag,
                           input logic [3:0] attr);
        @(negedge clk);
        ent_we = 1'b1; ent_way = w; ent_idx = va[13:12]; ent_vpn = va[31:12];
        ent_ppn = ppn; ent_asid = tag; ent_attr = attr;
        @(negedge clk);
        ent_we = 1'b0;
    endtask

    task automatic set_tags(input logic [31:0] v);
        @(negedge clk);
        asid_we = 1'b1; asid_wdata = v;
        @(negedge clk);
        asid_we = 1'b0;
    endtask

    task automatic look(input logic [31:0] va, input logic [1:0] kind, input logic [1:0] priv);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_priv = priv;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic refill(input logic [31:0] va, input logic [31:0] pte);
        @(negedge clk);
        fill_valid = 1'b1; fill_vaddr = va; fill_pte = pte;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R10 idle done", {31'd0, done_o}, 32'd0);
        chk("R10 idle fault", {31'd0, fault_o}, 32'd0);
        look(32'h0000_0000, 2'd0, 2'd0);
        chk("R10 done after req", {31'd0, done_o}, 32'd1);
        chk("R9 load misses after reset", {28'd0, cause_o}, 32'd5);
        chk("R10 fault flag", {31'd0, fault_o}, 32'd1);
        look(32'h1234_5678, 2'd2, 2'd0);
        chk("R9 fetch misses after reset", {28'd0, cause_o}, 32'd1);
        @(negedge clk);
        chk("R10 done one cycle only", {31'd0, done_o}, 32'd0);
    endtask

    task automatic t_basic_hit;
        put_ent(2'd0, 32'h1234_5678, 20'hABCDE, 8'h01, 4'h3);
        look(32'h1234_5678, 2'd0, 2'd0);
        chk("R1 hit cause", {28'd0, cause_o}, 32'd0);
        chk("R6 paddr", paddr_o, 32'hABCD_E678);
        chk("R6 way", {30'd0, way_o}, 32'd0);
        chk("R5 data rights drop X", {29'd0, rights_o}, 32'b011);
        chk("R2 ring from reset tags", {30'd0, ring_o}, 32'd0);
        look(32'h1234_5FFF, 2'd1, 2'd0);
        chk("R5 store allowed", {28'd0, cause_o}, 32'd0);
        chk("R6 paddr offset", paddr_o, 32'hABCD_EFFF);
        look(32'h1234_5000, 2'd2, 2'd0);
        chk("R5 fetch rights only X", {29'd0, rights_o}, 32'b100);
        look(32'h9234_5678, 2'd0, 2'd0);
        chk("R1 vpn mismatch misses", {28'd0, cause_o}, 32'd5);
        look(32'h9234_5678, 2'd3, 2'd0);
        chk("R1 fetch miss code", {28'd0, cause_o}, 32'd1);
    endtask

    task automatic t_rings;
        put_ent(2'd0, 32'h1234_5678, 20'hABCDE, 8'h03, 4'h3);
        look(32'h1234_5678, 2'd0, 2'd2);
        chk("R2 ring 2 for tag 03", {30'd0, ring_o}, 32'd2);
        chk("R4 ring equal priv ok", {28'd0, cause_o}, 32'd0);
        look(32'h1234_5678, 2'd0, 2'd3);
        chk("R4 data priv fault", {28'd0, cause_o}, 32'd7);
        look(32'h1234_5678, 2'd2, 2'd3);
        chk("R4 fetch priv fault", {28'd0, cause_o}, 32'd3);
        set_tags(32'h0303_0303);
        look(32'h1234_5678, 2'd0, 2'd0);
        chk("R2 lowest matching byte", {30'd0, ring_o}, 32'd0);
        set_tags(32'h0403_0201);
        put_ent(2'd0, 32'h1234_5678, 20'hABCDE, 8'h00, 4'h3);
        look(32'h1234_5678, 2'd0, 2'd0);
        chk("R1 zero tag misses", {28'd0, cause_o}, 32'd5);
    endtask

    task automatic t_multi;
        put_ent(2'd0, 32'h1234_5678, 20'hABCDE, 8'h01, 4'h3);
        put_ent(2'd2, 32'h1234_5000, 20'h11111, 8'h02, 4'h3);
        look(32'h1234_5678, 2'd0, 2'd0);
        chk("R3 data multi-hit", {28'd0, cause_o}, 32'd6);
        chk("R3 paddr zero", paddr_o, 32'd0);
        look(32'h1234_5678, 2'd2, 2'd0);
        chk("R3 fetch multi-hit", {28'd0, cause_o}, 32'd2);
        put_ent(2'd2, 32'h1234_5000, 20'h11111, 8'h00, 4'h3);
        look(32'h1234_5678, 2'd0, 2'd0);
        chk("R3 single hit again", {28'd0, cause_o}, 32'd0);
    endtask

    task automatic t_prot;
        put_ent(2'd1, 32'h0000_3000, 20'h55555, 8'h01, 4'h0);
        look(32'h0000_3010, 2'd0, 2'd0);
        chk("R5 read-only load ok", {28'd0, cause_o}, 32'd0);
        chk("R6 way 1", {30'd0, way_o}, 32'd1);
        look(32'h0000_3010, 2'd1, 2'd0);
        chk("R5 store prohibited", {28'd0, cause_o}, 32'd9);
        look(32'h0000_3010, 2'd2, 2'd0);
        chk("R5 fetch prohibited", {28'd0, cause_o}, 32'd4);
        put_ent(2'd1, 32'h0000_3000, 20'h55555, 8'h02, 4'h0);
        look(32'h0000_3010, 2'd1, 2'd2);
        chk("R10 priv before protection", {28'd0, cause_o}, 32'd7);
        put_ent(2'd1, 32'h0000_3000, 20'h55555, 8'h01, 4'd13);
        look(32'h0000_3010, 2'd1, 2'd0);
        chk("R5 code 13 store ok", {29'd0, rights_o}, 32'b011);
        look(32'h0000_3010, 2'd2, 2'd0);
        chk("R5 code 13 fetch prohibited", {28'd0, cause_o}, 32'd4);
        put_ent(2'd1, 32'h0000_3000, 20'h55555, 8'h01, 4'd14);
        look(32'h0000_3010, 2'd0, 2'd0);
        chk("R5 code 14 load prohibited", {28'd0, cause_o}, 32'd8);
    endtask

    task automatic t_pte;
        pt_base = 32'hC000_0000;
        look(32'h1234_5678, 2'd0, 2'd0);
        chk("R7 pte address", pte_addr_o, 32'hC004_8D14);
        pt_base = 32'h8000_0003;
        look(32'hFFFF_FFFF, 2'd2, 2'd0);
        chk("R7 pte low bits cleared", pte_addr_o, 32'h803F_FFFC);
    endtask

    task automatic t_refill;
        refill(32'h0040_1000, 32'h7777_7023);
        refill(32'h0040_5000, 32'h2222_2003);
        refill(32'h0040_9000, 32'h3333_3013);
        look(32'h0040_1ABC, 2'd0, 2'd0);
        chk("R8 first refill way 1", {30'd0, way_o}, 32'd1);
        chk("R8 refill ppn", paddr_o, 32'h7777_7ABC);
        chk("R8 refill tag from byte 2", {30'd0, ring_o}, 32'd2);
        chk("R8 refill attr", {29'd0, rights_o}, 32'b011);
        look(32'h0040_5000, 2'd0, 2'd0);
        chk("R8 second refill way 2", {30'd0, way_o}, 32'd2);
        look(32'h0040_9000, 2'd0, 2'd0);
        chk("R8 third refill way 3", {30'd0, way_o}, 32'd3);
        chk("R8 ring from pte bits", {30'd0, ring_o}, 32'd1);
        refill(32'h0040_D000, 32'h4444_4003);
        look(32'h0040_D000, 2'd0, 2'd0);
        chk("R8 fourth refill wraps to way 0", {30'd0, way_o}, 32'd0);
        look(32'h1234_5678, 2'd0, 2'd0);
        chk("R8 way 0 entry replaced", {28'd0, cause_o}, 32'd5);
        look(32'h0040_1000, 2'd0, 2'd0);
        chk("R8 way 1 entry kept", {28'd0, cause_o}, 32'd0);
    endtask

    initial begin : watchdog
        #(8 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; asid_we = 1'b0; asid_wdata = '0; ent_we = 1'b0;
        ent_way = '0; ent_idx = '0; ent_vpn = '0; ent_ppn = '0; ent_asid = '0;
        ent_attr = '0; pt_base = '0; req_valid = 1'b0; req_vaddr = '0;
        req_kind = '0; req_priv = '0; fill_valid = 1'b0; fill_vaddr = '0;
        fill_pte = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_hit();
        t_rings();
        t_multi();
        t_prot();
        t_pte();
        t_refill();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule